// File: doc/BRIEF.md
# Serial Character Receiver with Error-Tagged Receive Queue

This block receives asynchronous serial characters on a single line and turns them into parallel bytes for a processor. Each character has one start bit, five to eight data bits sent least significant bit first, an optional ninth bit, and a stop bit. The ninth bit can be checked as even or odd parity, or checked against a fixed value. In address-marking (multidrop) mode it is kept as an address/data marker. Timing comes from a sample-enable input that pulses sixteen times per bit period. No baud-rate divider is built in.

Each finished character goes into a three-entry queue together with its own framing flag and parity flag. The processor sees the character at the head of the queue and that character's flags, a ready indication, and a full indication. A one-cycle pop request removes the head character. When the queue is full, one more finished character can wait in a holding slot. If another character completes while that slot is occupied, the waiting character is replaced by the new one and a sticky overrun flag is raised. A clear-error pulse resets the overrun flag.

Top module: `serial_rx_status`

## Requirements
- R1: The character length is 5 + `cfg_len` data bits (`cfg_len` 0 to 3), received least significant bit first. `rx_data` holds the character right-justified, and every bit above the character length reads 0.
- R2: A falling edge on the line starts a character only if the line is still low at the middle of the start bit (8 sample pulses later). A shorter low pulse is ignored and produces no character.
- R3: The first stop bit is sampled at its midpoint. If it is low, the character is stored with `err_frame` = 1. Otherwise `err_frame` = 0.
- R4: `cfg_pmode` selects the handling of the bit after the data bits: 0 = no such bit, 1 = parity check, 2 = forced value check, 3 = address marker. In mode 1, `cfg_psel` = 0 selects even parity and 1 selects odd parity. `err_parity` = 1 when the count of ones over the data bits and the parity bit does not match the selected parity. In mode 0, `err_parity` = 0.
- R5: In mode 2, `err_parity` = 1 when the received bit differs from `cfg_psel`.
- R6: In mode 3, `err_parity` holds the received address/data bit as it arrived on the line.
- R7: The queue holds three characters. `rx_rdy` = 1 while at least one character is queued. `fifo_full` = 1 only when three are queued. `rx_data`, `err_frame` and `err_parity` describe the oldest character, and a pop removes it. After reset, `rx_rdy`, `fifo_full` and `err_overrun` are 0.
- R8: A character that completes while the queue is full waits in a single holding slot. It enters the queue on the clock edge that removes an entry, so the queue stays full, and it keeps its arrival order.
- R9: If a character completes while the queue is full and the holding slot is occupied, the waiting character and its flags are lost. The new character takes the slot and `err_overrun` becomes 1. Queued characters are unaffected.
- R10: `err_overrun` stays 1 through pops and further characters until a `clr_err` pulse. A new overrun in the same cycle as `clr_err` wins.
- R11: The receiver advances only on cycles with `sample_en` = 1. A low level on the line while `sample_en` stays 0 starts no character.
- R12: A pop while the queue is empty has no effect. `rx_rdy` stays 0, and the next character is read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Oversampling pulse, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data bits minus five |
| cfg_pmode | input | 2 | Ninth-bit mode: 0 none, 1 parity, 2 forced, 3 address marker |
| cfg_psel | input | 1 | Odd-parity select in mode 1, expected value in mode 2 |
| clr_err | input | 1 | Pulse clearing the overrun flag |
| pop | input | 1 | Remove the head character |
| rx_rdy | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds three characters |
| rx_data | output | 8 | Head character |
| err_frame | output | 1 | Head character had a low stop bit |
| err_parity | output | 1 | Head character parity result or address/data bit |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong bit counter or a misplaced sampling point shows up as a wrong `rx_data` or `err_frame` value. This appears on the edge after the stop-bit midpoint of the affected character, since the bench knows the exact cycle each character should arrive. A corrupted queue pointer or count shows up within one cycle of the next pop or push, as a `rx_rdy` or `fifo_full` level that disagrees with the bench's queue, or as a head character out of order. Mistakes in the holding slot or the overrun rule show up as a character that reappears or goes missing after the pops that follow an overrun, and as an `err_overrun` level that differs on any clock.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_CHECK = 2'd1,
    PAR_FORCE = 2'd2,
    PAR_ADDR  = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_deser.sv
module rx_deser
  import serial_rx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OSR  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  par_mode_e     cfg_pmode,
  input  logic          cfg_psel,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          done_fe,
  output logic          done_pe
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DW);
  localparam int NBW = $clog2(DW + 1);
  localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OSR - 1);

  logic [SYNC-1:0] sync_q;
  logic            rxd_s;
  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic [DW-1:0]   sh;
  logic            pacc;
  logic            pbit;
  logic [NBW-1:0]  nbits;
  logic [BW-1:0]   last_idx;
  logic            pe_calc;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], rxd};
  end
  assign rxd_s = sync_q[SYNC-1];

  assign nbits    = NBW'(5) + NBW'(cfg_len);
  assign last_idx = BW'(nbits - 1'b1);

  always_comb begin
    case (cfg_pmode)
      PAR_CHECK: pe_calc = pacc ^ pbit ^ cfg_psel;
      PAR_FORCE: pe_calc = pbit ^ cfg_psel;
      PAR_ADDR:  pe_calc = pbit;
      default:   pe_calc = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      sh        <= '0;
      pacc      <= 1'b0;
      pbit      <= 1'b0;
      done      <= 1'b0;
      done_data <= '0;
      done_fe   <= 1'b0;
      done_pe   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            cnt <= '0;
            if (!rxd_s) st <= RX_START;
          end
          RX_START: begin
            if (cnt == HALF) begin
              cnt  <= '0;
              bidx <= '0;
              pacc <= 1'b0;
              st   <= rxd_s ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt == FULL) begin
              cnt  <= '0;
              sh   <= {rxd_s, sh[DW-1:1]};
              pacc <= pacc ^ rxd_s;
              if (bidx == last_idx) st <= (cfg_pmode != PAR_NONE) ? RX_PAR : RX_STOP;
              else bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_PAR: begin
            if (cnt == FULL) begin
              cnt  <= '0;
              pbit <= rxd_s;
              st   <= RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == FULL) begin
              cnt       <= '0;
              st        <= RX_IDLE;
              done      <= 1'b1;
              done_data <= sh >> (NBW'(DW) - nbits);
              done_fe   <= ~rxd_s;
              done_pe   <= pe_calc;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_IDLE && $past(st) != RX_IDLE && !$past(rst)) |-> $past(st) == RX_START || $past(st) == RX_STOP);

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick) |=> $stable(st) && $stable(cnt));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 3,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [W-1:0]    wdata,
  input  logic            pop,
  output logic [W-1:0]    rdata,
  output logic [CNTW-1:0] count,
  output logic            empty,
  output logic            full,
  output logic            room
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic          pop_eff;

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign pop_eff = pop && !empty;
  assign room    = !full || pop_eff;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push)    wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_eff) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (push && !pop_eff)      count <= count + 1'b1;
      else if (!push && pop_eff) count <= count - 1'b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != CNTW'(DEPTH)) || pop);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNTW'(DEPTH));

  // R12
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OSR   = 16,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic [1:0]    cfg_pmode,
  input  logic          cfg_psel,
  input  logic          clr_err,
  input  logic          pop,
  output logic          rx_rdy,
  output logic          fifo_full,
  output logic [DW-1:0] rx_data,
  output logic          err_frame,
  output logic          err_parity,
  output logic          err_overrun
);
  localparam int EW   = DW + 2;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic          done;
  logic [DW-1:0] done_data;
  logic          done_fe;
  logic          done_pe;
  logic [EW-1:0] new_ent;
  logic [EW-1:0] hold_q;
  logic          hold_v;
  logic          push;
  logic [EW-1:0] wdata;
  logic [EW-1:0] head;
  logic [CNTW-1:0] count;
  logic          empty;
  logic          full;
  logic          room;
  logic          ovr_set;

  rx_deser #(.DW(DW), .OSR(OSR), .SYNC(2)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .tick      (sample_en),
    .rxd       (rxd),
    .cfg_len   (cfg_len),
    .cfg_pmode (par_mode_e'(cfg_pmode)),
    .cfg_psel  (cfg_psel),
    .done      (done),
    .done_data (done_data),
    .done_fe   (done_fe),
    .done_pe   (done_pe)
  );

  assign new_ent = {done_data, done_fe, done_pe};

  always_comb begin
    push  = 1'b0;
    wdata = hold_q;
    if (hold_v) begin
      push  = room;
      wdata = hold_q;
    end else if (done) begin
      push  = room;
      wdata = new_ent;
    end
  end

  assign ovr_set = hold_v && done && !room;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v      <= 1'b0;
      hold_q      <= '0;
      err_overrun <= 1'b0;
    end else begin
      if (hold_v) begin
        if (done)      hold_q <= new_ent;
        else if (room) hold_v <= 1'b0;
      end else if (done && !room) begin
        hold_v <= 1'b1;
        hold_q <= new_ent;
      end
      if (ovr_set)      err_overrun <= 1'b1;
      else if (clr_err) err_overrun <= 1'b0;
    end
  end

  rx_fifo #(.W(EW), .DEPTH(DEPTH), .CNTW(CNTW)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (wdata),
    .pop   (pop),
    .rdata (head),
    .count (count),
    .empty (empty),
    .full  (full),
    .room  (room)
  );

  assign rx_rdy     = !empty;
  assign fifo_full  = full;
  assign rx_data    = head[EW-1:2];
  assign err_frame  = head[1];
  assign err_parity = head[0];

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_overrun && !clr_err) |=> err_overrun);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done && hold_v && !room) |=> err_overrun && hold_v);

  // R8
  hold_only_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    hold_v |-> full);
endmodule

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_pmode = 2'd0;
  logic       cfg_psel = 1'b0;
  logic       clr_err = 1'b0;
  logic       pop = 1'b0;
  logic       rx_rdy, fifo_full, err_frame, err_parity, err_overrun;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  serial_rx_status u_dut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_pmode(cfg_pmode), .cfg_psel(cfg_psel),
    .clr_err(clr_err), .pop(pop), .rx_rdy(rx_rdy), .fifo_full(fifo_full),
    .rx_data(rx_data), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun)
  );

  typedef struct { logic [7:0] d; bit fe; bit pe; } ent_t;

  ent_t  q[$];
  ent_t  hold_e, pend_e;
  bit    hv, ovr, pend_v;
  int    pend_edge;
  int    cyc;
  int    checks, errors;
  string cur_req = "R7";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference model: one update per clock edge
  always @(posedge clk) begin
    bit pe_, room, dn, setov;
    cyc = cyc + 1;
    if (rst) begin
      q.delete(); hv = 0; ovr = 0;
    end else begin
      pe_   = pop && (q.size() > 0);
      room  = (q.size() < 3) || pe_;
      dn    = pend_v && (cyc == pend_edge);
      setov = 0;
      if (dn) pend_v = 0;
      if (pe_) void'(q.pop_front());
      if (hv && room) begin
        q.push_back(hold_e);
        if (dn) hold_e = pend_e; else hv = 0;
      end else if (hv) begin
        if (dn) begin hold_e = pend_e; setov = 1; end
      end else if (dn) begin
        if (room) q.push_back(pend_e);
        else begin hold_e = pend_e; hv = 1; end
      end
      if (setov) ovr = 1;
      else if (clr_err) ovr = 0;
    end
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL watchdog all actual=running expected=finished");
      finish_run();
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(rx_rdy == (q.size() > 0), cur_req, "rx_rdy", int'(rx_rdy), int'(q.size() > 0));
      chk(fifo_full == (q.size() == 3), cur_req, "fifo_full", int'(fifo_full), int'(q.size() == 3));
      chk(err_overrun == ovr, cur_req, "err_overrun", int'(err_overrun), int'(ovr));
      if (q.size() > 0) begin
        chk(rx_data == q[0].d, cur_req, "rx_data", int'(rx_data), int'(q[0].d));
        chk(err_frame == q[0].fe, cur_req, "err_frame", int'(err_frame), int'(q[0].fe));
        chk(err_parity == q[0].pe, cur_req, "err_parity", int'(err_parity), int'(q[0].pe));
      end
    end
  end

  // send one character; flag is a parity error request (modes 1, 2) or the address bit (mode 3)
  task automatic tx(input logic [7:0] d, input bit flag, input bit stopv);
    int   nb;
    int   b;
    bit   pb;
    logic [7:0] dm;
    nb = 5 + int'(cfg_len);
    dm = d & 8'((1 << nb) - 1);
    case (cfg_pmode)
      2'd1:    pb = (^dm) ^ cfg_psel ^ flag;
      2'd2:    pb = cfg_psel ^ flag;
      default: pb = flag;
    endcase
    b = nb + ((cfg_pmode != 2'd0) ? 1 : 0);
    @(negedge clk);
    rxd = 1'b0;
    pend_e.d  = dm;
    pend_e.fe = !stopv;
    pend_e.pe = (cfg_pmode != 2'd0) ? flag : 1'b0;
    pend_edge = cyc + 1 + 27 + 16 * b;
    pend_v    = 1;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    if (cfg_pmode != 2'd0) begin
      rxd = pb;
      repeat (16) @(negedge clk);
    end
    rxd = stopv;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) do_pop();
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk(!rx_rdy && !fifo_full && !err_overrun, "R7", "reset state", int'({rx_rdy, fifo_full, err_overrun}), 0);

    // R1 lengths
    cur_req = "R1";
    cfg_pmode = 2'd0;
    cfg_len = 2'd3; tx(8'hA5, 0, 1);
    chk(rx_data == 8'hA5, "R1", "8-bit data", int'(rx_data), 'hA5);
    drain();
    cfg_len = 2'd0; tx(8'hFF, 0, 1);
    chk(rx_data == 8'h1F, "R1", "5-bit data", int'(rx_data), 'h1F);
    drain();
    cfg_len = 2'd1; tx(8'hD6, 0, 1); drain();
    cfg_len = 2'd2; tx(8'h3C, 0, 1); drain();
    cfg_len = 2'd3;

    // R4 parity check even/odd
    cur_req = "R4";
    cfg_pmode = 2'd1; cfg_psel = 1'b0;
    tx(8'h37, 0, 1);
    chk(err_parity == 1'b0, "R4", "even good", int'(err_parity), 0);
    drain();
    tx(8'h37, 1, 1);
    chk(err_parity == 1'b1, "R4", "even bad", int'(err_parity), 1);
    drain();
    cfg_psel = 1'b1;
    tx(8'h80, 0, 1); tx(8'h81, 1, 1); drain();
    cfg_len = 2'd0; tx(8'h0B, 1, 1); drain(); cfg_len = 2'd3;

    // R5 forced value
    cur_req = "R5";
    cfg_pmode = 2'd2; cfg_psel = 1'b1;
    tx(8'h11, 0, 1);
    chk(err_parity == 1'b0, "R5", "forced match", int'(err_parity), 0);
    drain();
    cfg_psel = 1'b0;
    tx(8'h22, 1, 1);
    chk(err_parity == 1'b1, "R5", "forced mismatch", int'(err_parity), 1);
    drain();

    // R6 address marker
    cur_req = "R6";
    cfg_pmode = 2'd3;
    tx(8'h5A, 1, 1);
    chk(err_parity == 1'b1, "R6", "address bit 1", int'(err_parity), 1);
    drain();
    tx(8'h5B, 0, 1);
    chk(err_parity == 1'b0, "R6", "address bit 0", int'(err_parity), 0);
    drain();
    cfg_pmode = 2'd0;

    // R3 stop low
    cur_req = "R3";
    tx(8'h69, 0, 0);
    chk(err_frame == 1'b1, "R3", "low stop", int'(err_frame), 1);
    drain();
    tx(8'h6A, 0, 1);
    chk(err_frame == 1'b0, "R3", "good stop", int'(err_frame), 0);
    drain();

    // R2 glitch rejected
    cur_req = "R2";
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (60) @(negedge clk);
    chk(!rx_rdy, "R2", "glitch ignored", int'(rx_rdy), 0);

    // R11 no sample pulses
    cur_req = "R11";
    sample_en = 1'b0;
    @(negedge clk); rxd = 1'b0;
    repeat (40) @(negedge clk); rxd = 1'b1;
    repeat (8) @(negedge clk);
    sample_en = 1'b1;
    repeat (60) @(negedge clk);
    chk(!rx_rdy, "R11", "no start without sample_en", int'(rx_rdy), 0);

    // R7 / R8 fill and hold
    cur_req = "R8";
    tx(8'h01, 0, 1); tx(8'h02, 0, 1); tx(8'h03, 0, 1);
    chk(fifo_full, "R7", "three queued", int'(fifo_full), 1);
    tx(8'h04, 0, 1);
    chk(fifo_full && !err_overrun, "R8", "fourth waits", int'({fifo_full, err_overrun}), 2);

    // R9 overrun replaces waiting character
    cur_req = "R9";
    tx(8'h05, 1'b0, 0);
    chk(err_overrun, "R9", "overrun flag", int'(err_overrun), 1);
    do_pop();
    @(negedge clk);
    chk(rx_data == 8'h02 && fifo_full, "R8", "held char moved in", int'(rx_data), 'h02);
    do_pop(); do_pop();
    @(negedge clk);
    chk(rx_data == 8'h05 && err_frame, "R9", "replacement at head", int'(rx_data), 'h05);

    // R10 sticky until clear
    cur_req = "R10";
    drain();
    chk(err_overrun, "R10", "stays after pops", int'(err_overrun), 1);
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    chk(!err_overrun, "R10", "cleared", int'(err_overrun), 0);

    // R12 pop on empty
    cur_req = "R12";
    do_pop(); do_pop();
    chk(!rx_rdy, "R12", "empty pop", int'(rx_rdy), 0);
    tx(8'hC3, 0, 1);
    chk(rx_data == 8'hC3, "R12", "next char after empty pop", int'(rx_data), 'hC3);
    drain();

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule